// File: doc/BRIEF.md
# Boot-Window Command Sequencer

This block sits beside the register bus of a flash controller and watches writes that land in the boot window. These are the low boot region at offsets 0x0000 to 0x01FF and the short high region at 0x8000 to 0x800F. It turns those writes into commands. One command asks for a warm reset. One places identification bytes into the first three boot-buffer words. One starts a two-write page-load sequence. When a page load fires, the block turns the block-address and page-address start registers into a linear 512-byte sector number. It issues a single-cycle load request for a full 2 KB page, which is four sectors. In the same cycle it presents the new value for the page register, so that the register file can write it back.

Bus offsets outside the boot window are not decoded here. The block does not touch storage or the boot RAM. It only emits requests, and other logic acts on them. Every output is registered. A pulse appears during the clock cycle that follows the edge at which the bus write was sampled, and it lasts for one cycle.

Top module: `bootSeqTop`

## Requirements
- R1: Only writes with busOffset in 0x0000..0x01FF or 0x8000..0x800F are decoded. Any other write produces no output pulse and leaves a pending load armed.
- R2: A decoded write of 0x00F0, with no load pending, raises resetReq for exactly one cycle, in the cycle after the write.
- R3: A decoded write of 0x00E0 arms a pending load. The next decoded write always disarms it and is never treated as a command, whatever its value.
- R4: A decoded write of 0x0000 while armed raises loadValid for one cycle, with loadCount equal to 4. A non-zero value while armed produces no load.
- R5: loadSector equals page[1:0] + ((page[7:2] + (blk << 6)) << 2). Here page is start register 7 and blk is bits 11:0 of start register 0, ORed with the density mask when bit 15 of start register 0 is set. Page bits 15:8 and block bits 14:12 have no effect.
- R6: The density mask is 1 << (6 + devId[14:12]) when devId[11] is 1, and 0 when devId[11] is 0.
- R7: With every load, pageUpdValid pulses in the same cycle. pageUpdValue equals (page[7:0] + 4) mod 256, with bits 15:8 zero. The sector is computed from the page value before this increment.
- R8: A decoded write of 0x0090, with no load pending, raises idValid for one cycle. idWords[0] is {8'h00, devId[23:16]}, idWords[1] is {8'h00, devId[15:8]}, and idWords[2] is {8'h00, wpStatus[7:0]}.
- R9: Any other decoded value with no load pending is ignored. It produces no pulse and does not arm a load.
- R10: After reset all pulse outputs are low and no load is pending, so a decoded 0x0000 write produces no load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Register-bus write strobe |
| busOffset | input | 16 | Register-bus word offset |
| busData | input | 16 | Register-bus write data |
| startAddr | input | 8x16 | Start-address registers; entry 0 is the block, entry 7 is the page |
| devId | input | 24 | Device identification word |
| wpStatus | input | 16 | Write-protection status |
| loadValid | output | 1 | One-cycle page-load request |
| loadSector | output | 22 | Linear sector number of the load |
| loadCount | output | 3 | Sectors in the load (always 4) |
| pageUpdValid | output | 1 | Page-register write-back strobe |
| pageUpdValue | output | 16 | New page-register value |
| idValid | output | 1 | One-cycle identification-word write |
| idWords | output | 3x16 | Identification words 0..2 |
| resetReq | output | 1 | One-cycle warm-reset request |

## Verification
On every cycle, the assertions check these properties:
- At most one command pulse fires at a time.
- Any decoded write disarms a pending load.
- An out-of-window write leaves the armed flag alone.
- Each load carries a count of four and a page write-back four above the sector's low byte.
- The upper bytes of the write-back and the ID words stay zero.

Only the bench scenarios can show the rest:
- The full sector arithmetic across density configurations and block values.
- The exact boundaries of the boot window.
- The consumption of a command value that arrives while a load is armed.
- The correct ID byte placement.

// File: rtl/bootSeqPkg.sv
`timescale 1ns/1ps
package bootSeqPkg;

  // Strobes passed from the control to the datapath, one per command.
  typedef struct packed {
    logic doLoad;
    logic doId;
    logic doReset;
  } bootStrobeT;

  localparam logic [15:0] CMD_WARM_RESET = 16'h00F0;
  localparam logic [15:0] CMD_ARM_LOAD   = 16'h00E0;
  localparam logic [15:0] CMD_READ_ID    = 16'h0090;
  localparam logic [15:0] LOAD_CONFIRM   = 16'h0000;

  // Positions of the start-address registers that the datapath reads.
  localparam int BLOCK_REG_IDX = 0;
  localparam int PAGE_REG_IDX  = 7;

endpackage

// File: rtl/bootSeqCtrl.sv
`timescale 1ns/1ps
module bootSeqCtrl
  import bootSeqPkg::*;
#(
  parameter int OFS_W = 16,
  parameter int DATA_W = 16,
  parameter logic [OFS_W-1:0] LOW_LAST = 16'h01FF,
  parameter logic [OFS_W-1:0] HIGH_FIRST = 16'h8000,
  parameter logic [OFS_W-1:0] HIGH_LAST = 16'h800F
) (
  input  logic clk,
  input  logic rstN,
  input  logic busWrEn,
  input  logic [OFS_W-1:0] busOffset,
  input  logic [DATA_W-1:0] busData,
  output bootStrobeT strobe
);

  logic inBoot;
  logic bootWr;
  logic armed;
  logic armedNext;

  always_comb begin
    inBoot = (busOffset <= LOW_LAST) ||
             ((busOffset >= HIGH_FIRST) && (busOffset <= HIGH_LAST));
    bootWr = busWrEn && inBoot;
  end

  always_comb begin
    strobe = '0;
    armedNext = armed;
    if (bootWr) begin
      if (armed) begin
        // The second write of the load sequence is consumed here, whatever its value.
        armedNext = 1'b0;
        strobe.doLoad = (busData == DATA_W'(LOAD_CONFIRM));
      end else begin
        case (busData)
          DATA_W'(CMD_WARM_RESET): strobe.doReset = 1'b1;
          DATA_W'(CMD_ARM_LOAD):   armedNext = 1'b1;
          DATA_W'(CMD_READ_ID):    strobe.doId = 1'b1;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= armedNext;
  end

  // R3: a decoded write always consumes a pending load.
  a_r3_arm_consumed: assert property (@(posedge clk) disable iff (!rstN)
    (bootWr && armed) |=> !armed);

  // R3: no command is decoded while a load is pending.
  a_r3_no_cmd_when_armed: assert property (@(posedge clk) disable iff (!rstN)
    armed |-> !strobe.doReset && !strobe.doId);

  // R1: a write outside the window leaves the pending state untouched.
  a_r1_outside_keeps_arm: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && !inBoot) |=> $stable(armed));

  // R9: at most one command is decoded per cycle.
  a_r9_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.doLoad, strobe.doId, strobe.doReset}));

endmodule

// File: rtl/bootSeqDatapath.sv
`timescale 1ns/1ps
module bootSeqDatapath
  import bootSeqPkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ID_W = 24,
  parameter int BLK_W = 14,
  parameter int PAGE_SECS = 4,
  parameter int PAGE_STEP = 4,
  localparam int PG_W = 8,
  localparam int SEC_W = BLK_W + PG_W,
  localparam int CNT_W = $clog2(PAGE_SECS + 1),
  localparam int ID_WORDS = 3
) (
  input  logic clk,
  input  logic rstN,
  input  bootStrobeT strobe,
  input  logic [7:0][DATA_W-1:0] startAddr,
  input  logic [ID_W-1:0] devId,
  input  logic [DATA_W-1:0] wpStatus,
  output logic loadValid,
  output logic [SEC_W-1:0] loadSector,
  output logic [CNT_W-1:0] loadCount,
  output logic pageUpdValid,
  output logic [DATA_W-1:0] pageUpdValue,
  output logic idValid,
  output logic [ID_WORDS-1:0][DATA_W-1:0] idWords,
  output logic resetReq
);

  logic [DATA_W-1:0] blockReg;
  logic [DATA_W-1:0] pageReg;
  logic [BLK_W-1:0] densMask;
  logic [BLK_W-1:0] blkNum;
  logic [SEC_W-1:0] sectorNext;
  logic [PG_W-1:0] pageNext;
  logic [ID_WORDS-1:0][7:0] idSrc;

  assign blockReg = startAddr[BLOCK_REG_IDX];
  assign pageReg  = startAddr[PAGE_REG_IDX];

  // The density mask selects the upper half of the array on dual-die parts.
  always_comb begin
    densMask = devId[11] ? (BLK_W'(1) << (6 + int'(devId[14:12]))) : '0;
    blkNum   = BLK_W'(blockReg[11:0]) | (blockReg[15] ? densMask : '0);
  end

  // The sector number is taken from the page value before it is incremented.
  always_comb begin
    sectorNext = SEC_W'(pageReg[1:0]) +
                 ((SEC_W'(pageReg[7:2]) + (SEC_W'(blkNum) << 6)) << 2);
    pageNext   = pageReg[PG_W-1:0] + PG_W'(PAGE_STEP);
  end

  always_comb begin
    idSrc[0] = devId[ID_W-1 -: 8];
    idSrc[1] = devId[ID_W-9 -: 8];
    idSrc[2] = wpStatus[7:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      loadValid    <= 1'b0;
      loadSector   <= '0;
      loadCount    <= '0;
      pageUpdValid <= 1'b0;
      pageUpdValue <= '0;
      resetReq     <= 1'b0;
    end else begin
      loadValid    <= strobe.doLoad;
      pageUpdValid <= strobe.doLoad;
      resetReq     <= strobe.doReset;
      if (strobe.doLoad) begin
        loadSector   <= sectorNext;
        loadCount    <= CNT_W'(PAGE_SECS);
        pageUpdValue <= DATA_W'(pageNext);
      end
    end
  end

  // Each ID word is cleared and then receives its byte, zero-extended.
  always_ff @(posedge clk) begin
    if (!rstN) idValid <= 1'b0;
    else       idValid <= strobe.doId;
  end

  for (genvar w = 0; w < ID_WORDS; w++) begin : gIdWord
    always_ff @(posedge clk) begin
      if (!rstN)             idWords[w] <= '0;
      else if (strobe.doId)  idWords[w] <= DATA_W'(idSrc[w]);
    end
  end

  // R4: every load covers one full page.
  a_r4_full_page: assert property (@(posedge clk) disable iff (!rstN)
    loadValid |-> loadCount == CNT_W'(PAGE_SECS));

  // R7: the write-back value is four above the low byte of the pre-increment page.
  a_r7_page_step: assert property (@(posedge clk) disable iff (!rstN)
    loadValid |-> pageUpdValid &&
      (pageUpdValue[PG_W-1:0] == PG_W'(loadSector[PG_W-1:0] + PG_W'(PAGE_STEP))));

  // R7: the write-back wraps within one byte.
  a_r7_page_high_zero: assert property (@(posedge clk) disable iff (!rstN)
    pageUpdValid |-> pageUpdValue[DATA_W-1:PG_W] == '0);

  // R8: the ID words carry only a low byte.
  a_r8_id_high_zero: assert property (@(posedge clk) disable iff (!rstN)
    idValid |-> (idWords[0][DATA_W-1:8] == '0) && (idWords[1][DATA_W-1:8] == '0) &&
                (idWords[2][DATA_W-1:8] == '0));

  // R9: at most one request is issued per cycle.
  a_r9_one_pulse: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({loadValid, idValid, resetReq}));

endmodule

// File: rtl/bootSeqTop.sv
`timescale 1ns/1ps
module bootSeqTop
  import bootSeqPkg::*;
#(
  parameter int OFS_W = 16,
  parameter int DATA_W = 16,
  parameter int ID_W = 24,
  parameter int BLK_W = 14,
  parameter int PAGE_SECS = 4,
  parameter int PAGE_STEP = 4,
  localparam int SEC_W = BLK_W + 8,
  localparam int CNT_W = $clog2(PAGE_SECS + 1)
) (
  input  logic clk,
  input  logic rstN,
  input  logic busWrEn,
  input  logic [OFS_W-1:0] busOffset,
  input  logic [DATA_W-1:0] busData,
  input  logic [7:0][DATA_W-1:0] startAddr,
  input  logic [ID_W-1:0] devId,
  input  logic [DATA_W-1:0] wpStatus,
  output logic loadValid,
  output logic [SEC_W-1:0] loadSector,
  output logic [CNT_W-1:0] loadCount,
  output logic pageUpdValid,
  output logic [DATA_W-1:0] pageUpdValue,
  output logic idValid,
  output logic [2:0][DATA_W-1:0] idWords,
  output logic resetReq
);

  bootStrobeT strobe;

  bootSeqCtrl #(
    .OFS_W(OFS_W), .DATA_W(DATA_W)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busOffset(busOffset),
    .busData(busData), .strobe(strobe)
  );

  bootSeqDatapath #(
    .DATA_W(DATA_W), .ID_W(ID_W), .BLK_W(BLK_W),
    .PAGE_SECS(PAGE_SECS), .PAGE_STEP(PAGE_STEP)
  ) uPath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .startAddr(startAddr),
    .devId(devId), .wpStatus(wpStatus), .loadValid(loadValid),
    .loadSector(loadSector), .loadCount(loadCount), .pageUpdValid(pageUpdValid),
    .pageUpdValue(pageUpdValue), .idValid(idValid), .idWords(idWords),
    .resetReq(resetReq)
  );

endmodule

// File: tb/test_bootSeqTop.sv
`timescale 1ns/1ps
module test_bootSeqTop;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWrEn = 1'b0;
  logic [15:0] busOffset = '0;
  logic [15:0] busData = '0;
  logic [7:0][15:0] startAddr = '0;
  logic [23:0] devId = 24'hEC_40_00;
  logic [15:0] wpStatus = 16'h0002;
  logic loadValid;
  logic [21:0] loadSector;
  logic [2:0] loadCount;
  logic pageUpdValid;
  logic [15:0] pageUpdValue;
  logic idValid;
  logic [2:0][15:0] idWords;
  logic resetReq;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  bootSeqTop i_bootSeqTop (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busOffset(busOffset),
    .busData(busData), .startAddr(startAddr), .devId(devId), .wpStatus(wpStatus),
    .loadValid(loadValid), .loadSector(loadSector), .loadCount(loadCount),
    .pageUpdValid(pageUpdValid), .pageUpdValue(pageUpdValue), .idValid(idValid),
    .idWords(idWords), .resetReq(resetReq)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Drives one write; on return the registered response is visible.
  task automatic bootWrite(input logic [15:0] ofs, input logic [15:0] data);
    @(negedge clk);
    busWrEn = 1'b1;
    busOffset = ofs;
    busData = data;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic expectQuiet(input string req);
    chk(req, "pulses", {loadValid, pageUpdValid, idValid, resetReq}, 0);
  endtask

  function automatic int expSector(input logic [15:0] blkR, input logic [15:0] pageR,
                                   input logic [23:0] id);
    int mask = id[11] ? (1 << (6 + int'(id[14:12]))) : 0;
    int blk = int'(blkR[11:0]) | (blkR[15] ? mask : 0);
    return int'(pageR[1:0]) + ((int'(pageR[7:2]) + (blk << 6)) << 2);
  endfunction

  function automatic logic inWindow(input logic [15:0] ofs);
    return (ofs <= 16'h01FF) || (ofs >= 16'h8000 && ofs <= 16'h800F);
  endfunction

  initial begin
    #1_000_000;
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] blocks[6] = '{16'h0000, 16'h0ABC, 16'h8FFF, 16'h8001, 16'hF123, 16'h7FFF};
    logic [15:0] pages[7] = '{16'h0000, 16'h0005, 16'h007F, 16'h00FC, 16'h00FF, 16'hAB37, 16'h01FE};
    logic [15:0] offs[9] = '{16'h0000, 16'h01FF, 16'h0200, 16'h7FFF, 16'h8000,
                             16'h800F, 16'h8010, 16'hF220, 16'hFFFF};

    repeat (3) @(negedge clk);
    // R10: reset state
    expectQuiet("R10");
    rstN = 1'b1;
    @(negedge clk);
    expectQuiet("R10");
    bootWrite(16'h0000, 16'h0000);
    expectQuiet("R10");

    // R2: warm reset pulse and its width
    bootWrite(16'h0004, 16'h00F0);
    chk("R2", "resetReq", resetReq, 1);
    @(negedge clk);
    chk("R2", "resetReq width", resetReq, 0);

    // R1: window boundaries
    foreach (offs[i]) begin
      bootWrite(offs[i], 16'h00F0);
      chk("R1", $sformatf("resetReq ofs %0h", offs[i]), resetReq, inWindow(offs[i]));
    end

    // R1: an out-of-window write leaves the armed load in place
    startAddr[0] = 16'h0003;
    startAddr[7] = 16'h0010;
    bootWrite(16'h0010, 16'h00E0);
    expectQuiet("R3");
    bootWrite(16'h0200, 16'h0000);
    expectQuiet("R1");
    bootWrite(16'h8005, 16'h0000);
    chk("R1", "armed survives", loadValid, 1);

    // R3: a command value while armed is consumed
    bootWrite(16'h0000, 16'h00E0);
    bootWrite(16'h0000, 16'h00F0);
    expectQuiet("R3");
    bootWrite(16'h0000, 16'h00F0);
    chk("R3", "reset after disarm", resetReq, 1);
    // R4: a non-zero confirm produces no load and disarms
    bootWrite(16'h0000, 16'h00E0);
    bootWrite(16'h0000, 16'h1234);
    expectQuiet("R4");
    bootWrite(16'h0000, 16'h0000);
    expectQuiet("R3");

    // R4 R5 R6 R7: sweep density configurations, blocks and pages
    for (int cfg = 0; cfg < 16; cfg++) begin
      devId = {8'hEC, 8'h40, 1'b0, cfg[2:0], cfg[3], 11'h000};
      foreach (blocks[b]) begin
        foreach (pages[p]) begin
          startAddr[0] = blocks[b];
          startAddr[7] = pages[p];
          bootWrite(16'h0100, 16'h00E0);
          bootWrite((p % 2) ? 16'h800A : 16'h0000, 16'h0000);
          chk("R4", "loadValid", loadValid, 1);
          chk("R4", "loadCount", loadCount, 4);
          chk("R5", "loadSector", loadSector, expSector(blocks[b], pages[p], devId));
          chk("R7", "pageUpdValid", pageUpdValid, 1);
          chk("R7", "pageUpdValue", pageUpdValue, (int'(pages[p][7:0]) + 4) % 256);
          @(negedge clk);
          chk("R4", "load width", loadValid, 0);
        end
      end
    end

    // R6: density mask at the top setting selects block bit 13
    devId = {8'hEC, 8'h58, 8'h00} | 24'h000800 | 24'h007000;
    startAddr[0] = 16'h8000;
    startAddr[7] = 16'h0000;
    bootWrite(16'h0000, 16'h00E0);
    bootWrite(16'h0000, 16'h0000);
    chk("R6", "top mask sector", loadSector, (1 << 13) << 8);

    // R8: identification words
    for (int k = 0; k < 4; k++) begin
      devId = {8'(8'h11 * (k + 1)), 8'(8'h5A ^ k), 8'hC3};
      wpStatus = 16'(16'hA500 | (k * 37));
      bootWrite(16'h800F, 16'h0090);
      chk("R8", "idValid", idValid, 1);
      chk("R8", "word0", idWords[0], {8'h00, devId[23:16]});
      chk("R8", "word1", idWords[1], {8'h00, devId[15:8]});
      chk("R8", "word2", idWords[2], {8'h00, wpStatus[7:0]});
      @(negedge clk);
      chk("R8", "id width", idValid, 0);
    end

    // R9: all other low-byte values and a few wide ones are ignored and do not arm
    for (int v = 0; v < 260; v++) begin
      logic [15:0] val = (v < 256) ? 16'(v) : ((v == 256) ? 16'h10F0 :
                         (v == 257) ? 16'h01E0 : (v == 258) ? 16'hFFFF : 16'h8090);
      if (val != 16'h00F0 && val != 16'h00E0 && val != 16'h0090) begin
        bootWrite(16'h0040, val);
        expectQuiet("R9");
        bootWrite(16'h0040, 16'h0000);
        expectQuiet("R9");
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule